// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block controls one bank of up to 32 pins through a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Each pin is set up on its own as a general input, a general output or an interrupt input. An output pin drives either its output-data bit or a functional alternate signal that the surrounding logic supplies.

Interrupt pins are sampled through a two-flop synchronizer. The polarity bit qualifies the sampled level, which inverts it for active-low or falling-edge use. Each pin then sets a status bit in one of two ways. In level mode the bit follows the qualified level. In edge mode it latches a rising transition of the qualified level, or any transition when both-edge mode is on. Software clears latched edge status by writing ones, and enables pins through separate mask-enable and mask-write registers. A single active-high interrupt line reports any unmasked pending status.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, `pin_oe_o`, `pin_o` and `irq_o` are 0, and all pins are general inputs with interrupts disabled.
- R2: The register map uses these byte offsets: 0x00 direction (1 = output), 0x04 output data, 0x08 pin read, 0x0C mode (1 = interrupt input), 0x10 polarity (1 = inverted), 0x14 trigger (1 = edge, 0 = level), 0x18 both-edge, 0x1C status (read-only), 0x20 status clear (reads 0), 0x24 mask, 0x28 mask enable, 0x2C output source, 0x30 filter enable (storage only). Writable configuration registers read back the value last written. The registers at 0x08 and 0x1C ignore writes.
- R3: `pin_oe_o[i]` is 1 exactly when direction bit i is 1 and mode bit i is 0.
- R4: `pin_o[i]` equals output-data bit i when output-source bit i is 0, and `alt_i[i]` when it is 1. Output data written while a pin is an input appears on `pin_o` as soon as the pin turns to output.
- R5: Reading 0x08 returns the output-data bit for pins that drive (direction 1, mode 0). For all other pins it returns `pin_i` delayed by two clock edges.
- R6: For an interrupt pin in level mode, the status bit equals `pin_i` XOR polarity, three clock edges after `pin_i` changes. Writing the clear register does not change it.
- R7: For an interrupt pin in edge mode with both-edge 0, a 0-to-1 transition of `pin_i` XOR polarity sets the status bit. The bit then stays 1 until it is cleared, whatever the pin does.
- R8: With both-edge 1, an edge-mode pin sets its status on rising and on falling transitions of `pin_i`.
- R9: Writing 1 to a bit of 0x20 clears that pin's latched edge status on the next edge. Bits written as 0 have no effect.
- R10: Writing 0x28 sets each mask bit written as 1 and leaves the other mask bits unchanged.
- R11: Writing 0x24 clears each mask bit written as 0 and keeps each bit written as 1. A value with a single zero therefore disables exactly one pin.
- R12: `irq_o` is the OR over pins of status AND mask. Pins whose mode bit is 0 keep a status bit of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_i | input | NPINS | Pin input levels |
| alt_i | input | NPINS | Alternate output source |
| pin_o | output | NPINS | Pin output values |
| pin_oe_o | output | NPINS | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Each interrupt mode is driven with pin pulses in both directions: level high and low, rising edge, falling edge through the polarity bit, and both-edge. These runs tell apart a status that tracks the pin from one that latches it, and separate the cases where the polarity or both-edge setting is applied from those where it is missed. Clear writes are issued with the pin's bit set, with the bit zero, and against a level-mode pin, to separate W1C behaviour from a plain overwrite. Mask tests use single-zero direct writes and set-style writes while status is pending, which tells gating apart from status loss. Output tests write data before the direction change and switch the output source, to show retention and source selection.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_DIR  = 8'h00;
  localparam addr_t A_OUT  = 8'h04;
  localparam addr_t A_PIN  = 8'h08;
  localparam addr_t A_MODE = 8'h0C;
  localparam addr_t A_POL  = 8'h10;
  localparam addr_t A_TRIG = 8'h14;
  localparam addr_t A_BOTH = 8'h18;
  localparam addr_t A_STAT = 8'h1C;
  localparam addr_t A_CLR  = 8'h20;
  localparam addr_t A_MASK = 8'h24;
  localparam addr_t A_MEN  = 8'h28;
  localparam addr_t A_OSRC = 8'h2C;
  localparam addr_t A_FILT = 8'h30;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] mode_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] edge_i,
  input  logic [NPINS-1:0] both_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] stat_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic qual, prev_q, stat_q, det;

    assign qual = lvl_i[i] ^ pol_i[i];
    // rising of qualified level, or any change in both-edge mode
    assign det  = both_i[i] ? (qual ^ prev_q) : (qual & ~prev_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        stat_q <= 1'b0;
      end else begin
        prev_q <= qual;
        if (!mode_i[i])      stat_q <= 1'b0;
        else if (!edge_i[i]) stat_q <= qual;
        else                 stat_q <= (stat_q & ~clr_i[i]) | det;
      end
    end

    assign stat_o[i] = stat_q;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [NPINS-1:0]  alt_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  localparam int PW = NPINS;

  logic [PW-1:0] dir_q, out_q, mode_q, pol_q, edge_q, both_q;
  logic [PW-1:0] mask_q, osrc_q, filt_q;
  logic [PW-1:0] sync_w, stat_w, clr_w, wd, drive_w, pin_rd;
  logic [PW-1:0] rd_v;

  assign wd    = wdata_i[PW-1:0];
  assign clr_w = (we_i && addr_i == A_CLR) ? wd : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
      mask_q <= '0;
      osrc_q <= '0;
      filt_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_DIR:   dir_q  <= wd;
        A_OUT:   out_q  <= wd;
        A_MODE:  mode_q <= wd;
        A_POL:   pol_q  <= wd;
        A_TRIG:  edge_q <= wd;
        A_BOTH:  both_q <= wd;
        A_MASK:  mask_q <= mask_q & wd;
        A_MEN:   mask_q <= mask_q | wd;
        A_OSRC:  osrc_q <= wd;
        A_FILT:  filt_q <= wd;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(PW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  gpio_irq_detect #(.NPINS(PW)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_w),
    .mode_i(mode_q),
    .pol_i (pol_q),
    .edge_i(edge_q),
    .both_i(both_q),
    .clr_i (clr_w),
    .stat_o(stat_w)
  );

  assign drive_w  = dir_q & ~mode_q;
  assign pin_oe_o = drive_w;
  assign pin_o    = (out_q & ~osrc_q) | (alt_i & osrc_q);
  assign pin_rd   = (out_q & drive_w) | (sync_w & ~drive_w);
  assign irq_o    = |(stat_w & mask_q);

  always_comb begin
    unique case (addr_i)
      A_DIR:   rd_v = dir_q;
      A_OUT:   rd_v = out_q;
      A_PIN:   rd_v = pin_rd;
      A_MODE:  rd_v = mode_q;
      A_POL:   rd_v = pol_q;
      A_TRIG:  rd_v = edge_q;
      A_BOTH:  rd_v = both_q;
      A_STAT:  rd_v = stat_w;
      A_MASK:  rd_v = mask_q;
      A_OSRC:  rd_v = osrc_q;
      A_FILT:  rd_v = filt_q;
      default: rd_v = '0;
    endcase
  end

  assign rdata_o = DATA_W'(rd_v);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  edge_q,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  stat_w
);
  // R10
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MEN) |=> ((mask_q & $past(wdata_i[NPINS-1:0])) == $past(wdata_i[NPINS-1:0])));

  // R11
  mask_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MASK) |=> ((mask_q & ~$past(wdata_i[NPINS-1:0])) == '0));

  // R12
  stat_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_w & ~$past(mode_q)) == '0));

  // R7
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (($past(stat_w & mode_q & edge_q) & ~stat_w) == '0));

  // R12
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (!$stable(stat_w) || !$stable(mask_q)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o),
  .mode_q (mode_q),
  .edge_q (edge_q),
  .mask_q (mask_q),
  .stat_w (stat_w)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin = '0;
  logic [31:0] alt = '0;
  logic [31:0] pout, poe;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_bank #(.NPINS(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .alt_i(alt), .pin_o(pout), .pin_oe_o(poe),
    .irq_o(irq)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [79:0] VEC [14] = '{
    {8'h00, 32'h0000_00F0, 8'h00, 32'h0000_00F0},
    {8'h04, 32'hDEAD_BEEF, 8'h04, 32'hDEAD_BEEF},
    {8'h10, 32'h1234_5678, 8'h10, 32'h1234_5678},
    {8'h14, 32'h0F0F_0000, 8'h14, 32'h0F0F_0000},
    {8'h18, 32'h8000_0001, 8'h18, 32'h8000_0001},
    {8'h2C, 32'h0000_0100, 8'h2C, 32'h0000_0100},
    {8'h30, 32'hCAFE_0000, 8'h30, 32'hCAFE_0000},
    {8'h0C, 32'h0000_000F, 8'h0C, 32'h0000_000F},
    {8'h20, 32'hFFFF_FFFF, 8'h20, 32'h0000_0000},
    {8'h28, 32'h0000_00F3, 8'h24, 32'h0000_00F3},
    {8'h24, 32'hFFFF_FFFD, 8'h24, 32'h0000_00F1},
    {8'h28, 32'h0000_0004, 8'h24, 32'h0000_00F5},
    {8'h1C, 32'hFFFF_FFFF, 8'h1C, 32'h0000_0008},
    {8'h08, 32'hFFFF_FFFF, 8'h08, 32'h0000_00E0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin = '0; alt = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    rd(8'h00, v); chk("R1 dir", v, 0);
    rd(8'h24, v); chk("R1 mask", v, 0);
    rd(8'h0C, v); chk("R1 mode", v, 0);
    rd(8'h1C, v); chk("R1 stat", v, 0);
    chk("R1 oe", poe, 0);
    chk("R1 pin_o", pout, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 R5 R9 R10 R11 table
    for (int i = 0; i < 14; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], v);
      chk($sformatf("R2/R5/R9/R10/R11 row %0d", i), v, VEC[i][31:0]);
    end

    do_reset();
    // R4 retention, R3 enables
    wr(8'h04, 32'h3C);
    chk("R3 oe while input", poe, 0);
    wr(8'h00, 32'h3C);
    chk("R3 oe output", poe, 32'h3C);
    chk("R4 retained data", pout, 32'h3C);
    wr(8'h0C, 32'h04);
    chk("R3 oe masked by mode", poe, 32'h38);
    alt = 32'hFFFF_0000;
    wr(8'h2C, 32'h0001_0001);
    #1 chk("R4 output source", pout, 32'h0001_003C);
    // R5 pin read
    pin = 32'h0000_0F00;
    cyc(3);
    rd(8'h08, v); chk("R5 pin read", v, 32'h0000_0F38);

    do_reset();
    // R6 level high on pin 4
    wr(8'h0C, 32'h10);
    wr(8'h28, 32'h10);
    pin[4] = 1'b1; cyc(4);
    chk("R6 level high irq", {31'b0, irq}, 1);
    wr(8'h20, 32'h10); cyc(1);
    rd(8'h1C, v); chk("R6 clear ignored", v, 32'h10);
    pin[4] = 1'b0; cyc(4);
    chk("R6 level drop", {31'b0, irq}, 0);
    wr(8'h10, 32'h10); cyc(2);
    chk("R6 level low irq", {31'b0, irq}, 1);
    wr(8'h10, 32'h0); cyc(2);

    // R7 rising edge
    wr(8'h14, 32'h10);
    wr(8'h20, 32'h10); cyc(1);
    rd(8'h1C, v); chk("R7 cleared", v, 0);
    pin[4] = 1'b1; cyc(4);
    pin[4] = 1'b0; cyc(4);
    rd(8'h1C, v); chk("R7 latched", v, 32'h10);
    chk("R7 irq", {31'b0, irq}, 1);
    wr(8'h20, 32'h0); cyc(1);
    rd(8'h1C, v); chk("R9 zero write", v, 32'h10);
    wr(8'h20, 32'h10); cyc(1);
    rd(8'h1C, v); chk("R9 clear", v, 0);
    chk("R9 irq low", {31'b0, irq}, 0);

    // R12 gating, R11 single zero
    wr(8'h24, 32'hFFFF_FFEF);
    pin[4] = 1'b1; cyc(4);
    rd(8'h1C, v); chk("R12 status pending", v, 32'h10);
    chk("R12 masked irq", {31'b0, irq}, 0);
    wr(8'h28, 32'h10);
    chk("R10 enable raises irq", {31'b0, irq}, 1);

    // R7 falling via polarity
    wr(8'h10, 32'h10); cyc(2);
    wr(8'h20, 32'h10); cyc(1);
    rd(8'h1C, v); chk("R7 pre-fall clear", v, 0);
    pin[4] = 1'b0; cyc(4);
    rd(8'h1C, v); chk("R7 falling edge", v, 32'h10);

    // R8 both edges
    wr(8'h10, 32'h0); cyc(2);
    wr(8'h18, 32'h10);
    wr(8'h20, 32'h10); cyc(1);
    rd(8'h1C, v); chk("R8 cleared", v, 0);
    pin[4] = 1'b1; cyc(4);
    rd(8'h1C, v); chk("R8 rise", v, 32'h10);
    wr(8'h20, 32'h10); cyc(1);
    pin[4] = 1'b0; cyc(4);
    rd(8'h1C, v); chk("R8 fall", v, 32'h10);

    // R11 single zero
    wr(8'h28, 32'hFF);
    wr(8'h24, 32'hFFFF_FFF7);
    rd(8'h24, v); chk("R11 single zero", v, 32'hF7);

    // R12 non-interrupt pin
    pin[5] = 1'b1; cyc(4);
    rd(8'h1C, v); chk("R12 io pin no status", v, 32'h10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule